// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of the colour subcarrier for a composite video encoder. A 32-bit accumulator adds a programmable frequency increment on every clock. Its upper bits are passed on to a sine lookup that lives outside the block.

The phase can be forced back to a programmable origin value at a field boundary. This happens in two cases:

- An automatic realignment at the first field of each colour sequence. The sequence is four fields long for 525-line timing and eight fields long for 625-line timing.
- A realignment armed by a rising edge on an asynchronous reset pin. It takes effect at the next field boundary.

When the encoder is genlocked to an external source, the automatic realignment is suppressed so that the phase tracks the source. In that mode the frequency increment is only taken up at line starts.

Every pin-armed realignment also emits a one-clock pulse. The field timing generator uses this pulse to restart its field count at zero.

Top module: `subcarrier_dds`

## Requirements
- R1: While `rst_n` is low, `phase`, `phase_top` and `realign` are all zero.
- R2: With `rtc_mode` low and no realignment, `phase` grows each clock by the `freq_word` value sampled one clock earlier, modulo 2^32. The increment register is zero at reset.
- R3: With `auto_en` high and `rtc_mode` low, a clock that samples `field_start` high and a sequence-origin field number makes `phase` equal `phase_ofs` after that edge. A sequence-origin field number is one with `field_num[1:0]`==0 when `std_625`=0, and `field_num`==0 when `std_625`=1. `realign` is high in that same cycle.
- R4: With `std_625`=1, field number 4 is not a sequence origin. Eight consecutive fields numbered 0..7 give one automatic realignment under 625-line timing and two under 525-line timing.
- R5: `sc_rst_pin` passes through two synchronising flops. Take the first clock edge that samples it high after a low. A `field_start` sampled on the fourth or any later edge after that first edge reloads `phase` to `phase_ofs`. A `field_start` sampled on the third edge does not; the reload then waits for the following field start.
- R6: A pin-armed reload pulses `realign` for one cycle and clears the pending request. The field start after that does not reload unless R3 applies.
- R7: Several rising edges on `sc_rst_pin` before one field start cause a single reload.
- R8: With `rtc_mode` high, no automatic realignment occurs, whatever `auto_en` is. A pin-armed reload still occurs.
- R9: With `rtc_mode` high, the increment register takes `freq_word` only on clocks that sample `line_start` high. Otherwise it holds its value.
- R10: `phase_top` equals the upper `LUT_W` bits of `phase`.
- R11: With `auto_en` low and no rising edge on the pin, `phase` is never reloaded and `realign` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freq_word | input | 32 | Subcarrier frequency increment |
| phase_ofs | input | 32 | Field-0 phase origin value |
| field_start | input | 1 | One-clock strobe at the first clock of a field |
| line_start | input | 1 | One-clock strobe at the first clock of a line |
| field_num | input | 3 | Number of the field that starts with `field_start` |
| std_625 | input | 1 | 0: 525-line, 4-field sequence; 1: 625-line, 8-field sequence |
| auto_en | input | 1 | Enables automatic realignment at the sequence origin |
| sc_rst_pin | input | 1 | Asynchronous phase-reset request pin |
| rtc_mode | input | 1 | External genlock mode |
| phase | output | 32 | Accumulated subcarrier phase |
| phase_top | output | 10 | Upper phase bits for a sine lookup |
| realign | output | 1 | Pulses in the cycle a reload took effect |

## Verification
The bench builds the block with its defaults: a 32-bit accumulator, a 10-bit lookup slice, a 3-bit field number and two synchroniser stages. The short 12-clock fields and 4-clock lines of the bench allow a full eight-field 625-line sequence to be covered in about a hundred clocks. A frequency word above 2^31 wraps the accumulator within a few clocks. The 3-bit field number lets a single run visit both origins of the four-field sequence, and a pin edge armed in field 5 of the eight-field one.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } line_std_e;

  // True when the field number marks the first field of a colour sequence
  function automatic logic seq_origin(input line_std_e std, input logic [2:0] fnum);
    if (std == STD_625) seq_origin = (fnum == 3'd0);
    else                seq_origin = (fnum[1:0] == 2'd0);
  endfunction

endpackage

// File: rtl/sc_pin_edge.sv
module sc_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q, sync_d;
  logic          prev_q, prev_d;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], pin};
    end else begin : g_single
      always_comb sync_d = pin;
    end
  endgenerate

  always_comb prev_d = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  // a detected edge never lasts two cycles
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/sc_realign_ctl.sv
module sc_realign_ctl
  import dds_pkg::*;
#(
  parameter int FNUM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic [FNUM_W-1:0] field_num,
  input  logic              std_625,
  input  logic              auto_en,
  input  logic              rtc_mode,
  input  logic              pin_rise,
  output logic              reload,
  output logic              realign
);
  logic pend_q, pend_d;
  logic realign_q, realign_d;
  logic origin, auto_hit, pin_hit;

  always_comb begin
    origin    = seq_origin(line_std_e'(std_625), field_num[2:0]);
    auto_hit  = field_start & auto_en & ~rtc_mode & origin;
    pin_hit   = field_start & pend_q;
    reload    = auto_hit | pin_hit;
    // a new edge seen while a field starts arms the following field
    pend_d    = (pend_q & ~field_start) | pin_rise;
    realign_d = reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      realign_q <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      realign_q <= realign_d;
    end
  end

  assign realign = realign_q;

  assert_rtc_no_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_mode && !pend_q) |-> !reload);

  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && pend_q) |=> (!pend_q || $past(pin_rise)));

  assert_no_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !auto_en) |-> !reload);

endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [PHASE_W-1:0] phase_ofs,
  input  logic               rtc_mode,
  input  logic               line_start,
  input  logic               reload,
  output logic [PHASE_W-1:0] phase
);
  logic [PHASE_W-1:0] freq_q, freq_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               freq_en;

  always_comb begin
    freq_en = ~rtc_mode | line_start;
    freq_d  = freq_en ? freq_word : freq_q;
    phase_d = reload ? phase_ofs : phase_q + freq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q  <= '0;
      phase_q <= '0;
    end else begin
      freq_q  <= freq_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  assert_rtc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_mode && !line_start) |=> (freq_q == $past(freq_q)));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> (phase_q == $past(phase_q) + $past(freq_q)));

endmodule

// File: rtl/subcarrier_dds.sv
module subcarrier_dds #(
  parameter int PHASE_W     = 32,
  parameter int LUT_W       = 10,
  parameter int FNUM_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [PHASE_W-1:0] phase_ofs,
  input  logic               field_start,
  input  logic               line_start,
  input  logic [FNUM_W-1:0]  field_num,
  input  logic               std_625,
  input  logic               auto_en,
  input  logic               sc_rst_pin,
  input  logic               rtc_mode,
  output logic [PHASE_W-1:0] phase,
  output logic [LUT_W-1:0]   phase_top,
  output logic               realign
);
  localparam int TOP_MSB = PHASE_W - 1;

  logic pin_rise;
  logic reload;

  sc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (sc_rst_pin),
    .rise  (pin_rise)
  );

  sc_realign_ctl #(.FNUM_W(FNUM_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .field_num   (field_num),
    .std_625     (std_625),
    .auto_en     (auto_en),
    .rtc_mode    (rtc_mode),
    .pin_rise    (pin_rise),
    .reload      (reload),
    .realign     (realign)
  );

  sc_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_word  (freq_word),
    .phase_ofs  (phase_ofs),
    .rtc_mode   (rtc_mode),
    .line_start (line_start),
    .reload     (reload),
    .phase      (phase)
  );

  assign phase_top = phase[TOP_MSB -: LUT_W];

  // the realign pulse and the origin value arrive together
  assert_reload_val_R3: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> (phase == $past(phase_ofs)));

endmodule

// File: tb/sim_subcarrier_dds.sv
module sim_subcarrier_dds;
  localparam int FLEN = 12;
  localparam int LLEN = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] freq_word, phase_ofs;
  logic        field_start, line_start, std_625, auto_en, sc_rst_pin, rtc_mode;
  logic [2:0]  field_num;
  logic [31:0] phase;
  logic [9:0]  phase_top;
  logic        realign;

  always #2.5 clk = ~clk;

  subcarrier_dds u0 (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .phase_ofs(phase_ofs),
    .field_start(field_start), .line_start(line_start), .field_num(field_num),
    .std_625(std_625), .auto_en(auto_en), .sc_rst_pin(sc_rst_pin),
    .rtc_mode(rtc_mode), .phase(phase), .phase_top(phase_top), .realign(realign)
  );

  int n_chk = 0, n_bad = 0, n_realign = 0;
  bit done = 1'b0;

  // reference state, written from the requirements
  logic [31:0] m_phase, m_freq;
  logic        m_p0, m_p1, m_p2, m_pend, m_realign, m_pin_hit;

  // {std_625, auto_en, rtc_mode, pin field (F = none), freq base, origin}
  localparam logic [70:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b0, 4'hF, 32'h0123_4567, 32'h4000_0000},
    {1'b1, 1'b1, 1'b0, 4'hF, 32'h9000_0001, 32'h0000_0001},
    {1'b1, 1'b0, 1'b0, 4'h5, 32'h0765_4321, 32'hABCD_0000},
    {1'b0, 1'b1, 1'b1, 4'hF, 32'h0011_2233, 32'h1357_9BDF},
    {1'b1, 1'b1, 1'b1, 4'h2, 32'h0F0F_0F0F, 32'h8000_0000},
    {1'b0, 1'b0, 1'b0, 4'hF, 32'h00AB_CDEF, 32'h2222_2222}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic        rise, origin, rl;
    logic [31:0] n_phase, n_freq;
    rise    = m_p1 & ~m_p2;
    origin  = std_625 ? (field_num == 3'd0) : (field_num[1:0] == 2'd0);
    rl      = field_start & (m_pend | (auto_en & ~rtc_mode & origin));
    n_phase = rl ? phase_ofs : m_phase + m_freq;
    n_freq  = (rtc_mode & ~line_start) ? m_freq : freq_word;
    @(posedge clk);
    #1;
    m_pin_hit = field_start & m_pend;
    m_pend    = (m_pend & ~field_start) | rise;
    m_p2      = m_p1;
    m_p1      = m_p0;
    m_p0      = sc_rst_pin;
    m_phase   = n_phase;
    m_freq    = n_freq;
    m_realign = rl;
    if (realign) n_realign++;
    if (m_realign && m_pin_hit)  chk("R5", phase, m_phase);
    else if (m_realign)          chk("R3", phase, m_phase);
    else if (rtc_mode)           chk("R9", phase, m_phase);
    else                         chk("R2", phase, m_phase);
    chk("R6", {31'd0, realign}, {31'd0, m_realign});
    chk("R10", {22'd0, phase_top}, {22'd0, m_phase[31:22]});
  endtask

  // runs whole fields; pin pulses in field pf over clocks [pa, pb)
  task automatic run_fields(input int nf, input int pf, input int pa, input int pb,
                            input logic [31:0] base);
    for (int f = 0; f < nf; f++) begin
      for (int c = 0; c < FLEN; c++) begin
        field_start = (c == 0);
        line_start  = (c % LLEN == 0);
        sc_rst_pin  = (f == pf) && (c >= pa) && (c < pb);
        freq_word   = base + 32'(f * 97 + c * 13);
        tick();
      end
      field_num = field_num + 3'd1;
    end
  endtask

  task automatic quiet();
    field_start = 1'b0; line_start = 1'b0; sc_rst_pin = 1'b0; field_num = 3'd0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    quiet();
    freq_word = 32'h1111_1111; phase_ofs = 32'h7777_7777;
    std_625 = 1'b0; auto_en = 1'b1; rtc_mode = 1'b0;
    m_phase = '0; m_freq = '0; m_p0 = 0; m_p1 = 0; m_p2 = 0; m_pend = 0; m_realign = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held at zero in reset
    chk("R1", phase, 32'd0);
    chk("R1", {22'd0, phase_top}, 32'd0);
    chk("R1", {31'd0, realign}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      std_625   = VEC[v][70];
      auto_en   = VEC[v][69];
      rtc_mode  = VEC[v][68];
      phase_ofs = VEC[v][31:0];
      field_num = 3'd0;
      run_fields(10, int'(VEC[v][67:64]) == 15 ? -1 : int'(VEC[v][67:64]), 5, 9,
                 VEC[v][63:32]);
    end

    // R4: eight fields of automatic realignment per standard
    quiet(); auto_en = 1'b1; rtc_mode = 1'b0; std_625 = 1'b1;
    n_realign = 0;
    run_fields(8, -1, 0, 0, 32'h0101_0101);
    chk("R4", n_realign, 32'd1);
    quiet(); std_625 = 1'b0; n_realign = 0;
    run_fields(8, -1, 0, 0, 32'h0202_0202);
    chk("R4", n_realign, 32'd2);

    // R7: two edges in one field give one reload
    quiet(); auto_en = 1'b0; n_realign = 0;
    for (int c = 0; c < FLEN; c++) begin
      field_start = (c == 0);
      sc_rst_pin  = (c == 2) || (c == 3) || (c == 7) || (c == 8);
      tick();
    end
    sc_rst_pin = 1'b0; field_num = 3'd1;
    run_fields(3, -1, 0, 0, 32'h0303_0303);
    chk("R7", n_realign, 32'd1);

    // R8: genlock mode suppresses automatic realignment
    quiet(); auto_en = 1'b1; rtc_mode = 1'b1; n_realign = 0;
    run_fields(8, -1, 0, 0, 32'h0404_0404);
    chk("R8", n_realign, 32'd0);

    // R11: no cause, no reload
    quiet(); auto_en = 1'b0; rtc_mode = 1'b0; n_realign = 0;
    run_fields(8, -1, 0, 0, 32'h0505_0505);
    chk("R11", n_realign, 32'd0);

    // R5 boundary: edge sampled three edges before a field start waits a field
    quiet(); n_realign = 0;
    for (int c = 0; c < 2 * FLEN + 1; c++) begin
      field_start = (c == FLEN) || (c == 2 * FLEN);
      sc_rst_pin  = (c >= FLEN - 2) && (c < FLEN + 2);
      tick();
    end
    chk("R5", n_realign, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule